// File: doc/BRIEF.md
# Permuted Block Interleaver / Deinterleaver

The block reorders one frame of symbols through a matrix buffer with a run-time number of columns. In interleave mode the symbols enter row after row and leave column after column. The order in which the columns are visited comes from a small loadable permutation table. In deinterleave mode the same core undoes that mapping. It fills the matrix column by column in the permuted order and reads it out row by row. Channel coding chains use it to spread burst errors across a frame before decoding.

Symbols arrive on a valid/ready stream. A start-of-frame flag marks the first symbol of a frame. The mode, frame length and column count are captured with that first symbol. Only one frame is held at a time. The output stream opens once the frame is complete and marks its final symbol. A frame that ends early, or a symbol that arrives outside any frame, is reported on a one-cycle error pulse and discarded.

Top module: `symbol_interleaver`

## Requirements
- R1: With `cfg_mode`=0 (interleave), frame symbol k is stored at matrix position k, with row = k / cols. The output visits table slot 0, then slot 1, and so on up to slot cols-1. For each slot j it emits rows 0 to len/cols-1 of the column held in slot j.
- R2: With `cfg_mode`=1 (deinterleave), input symbols fill slot 0's column from row 0 down to the last row, then slot 1's column, and so on. The output reads the matrix row by row, each row from column 0 upward, which undoes R1 for the same table.
- R3: For a 9-symbol frame with 3 columns and an identity table, input 1..9 leaves as 1,4,7,2,5,8,3,6,9. Feeding that sequence back in deinterleave mode returns 1..9.
- R4: `out_valid` rises only in the cycle after the frame's final input symbol has been accepted. `in_ready` stays low while any output symbol of the frame is still pending.
- R5: `out_last` is high exactly with the final output symbol. After that symbol is taken, `out_valid` falls and `in_ready` returns high in the next cycle.
- R6: A table write (`tbl_wr_en`=1 puts column index `tbl_wr_col` into slot `tbl_wr_slot`) takes effect only while no frame is being filled or drained. Writes at any other time are ignored.
- R7: If a start-of-frame symbol is accepted before the current frame reached its length, `frame_err` pulses high in the next cycle. The partial frame is discarded, and the new symbol becomes symbol 0 of a fresh frame.
- R8: A symbol accepted while idle without the start-of-frame flag is dropped. It causes a one-cycle `frame_err` pulse and starts no frame.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R10: After reset `in_ready`=1, `out_valid`=0 and `frame_err`=0, and the table holds the identity (slot j -> column j).
- R11: Mode, length and column count are taken from the config inputs only with the start-of-frame symbol. Changes to them later in the frame have no effect. The length must be a non-zero multiple of the column count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | 0 = interleave, 1 = deinterleave |
| cfg_len | input | LEN_W | Frame length in symbols |
| cfg_cols | input | COL_W | Number of matrix columns |
| tbl_wr_en | input | 1 | Permutation table write strobe |
| tbl_wr_slot | input | IDX_W | Table slot (visit position) to write |
| tbl_wr_col | input | IDX_W | Column index stored in that slot |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Input symbol accepted when high |
| in_sof | input | 1 | Input symbol is the first of a frame |
| in_data | input | DATA_W | Input symbol |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream takes the output symbol |
| out_data | output | DATA_W | Output symbol |
| out_last | output | 1 | Output symbol is the final one of the frame |
| frame_err | output | 1 | One-cycle pulse on a discarded frame or stray symbol |

## Verification
Two events can land in one clock cycle: a new start-of-frame symbol and the abandonment of a partly filled frame. On that edge the core must drop the old frame, capture fresh configuration and store the new symbol at position zero. The bench provokes this by cutting a frame short after three symbols and sending a complete frame at once. It checks that `frame_err` pulses exactly on the following cycle and that the output matches the second frame alone. A second collision happens when a table write arrives in the same cycle as frame traffic. The bench issues writes during filling and draining, then shows through the output order of that frame and the next one that the table was left unchanged.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Frame life cycle: wait for a start symbol, fill the matrix, drain it.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

endpackage

// File: rtl/ilv_perm_table.sv
module ilv_perm_table #(
    parameter int MAX_COLS = 8,
    parameter int IDX_W    = $clog2(MAX_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [IDX_W-1:0] wr_col,
    input  logic [IDX_W-1:0] rd_slot,
    output logic [IDX_W-1:0] rd_col
);

    logic [IDX_W-1:0] slot_q [MAX_COLS];
    logic [IDX_W-1:0] slot_d [MAX_COLS];

    always_comb begin
        slot_d = slot_q;
        if (wr_en && (int'(wr_slot) < MAX_COLS)) begin
            slot_d[wr_slot] = wr_col;
        end
    end

    // Reset value is the identity visit order.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_COLS; i++) begin
                slot_q[i] <= IDX_W'(i);
            end
        end else begin
            slot_q <= slot_d;
        end
    end

    assign rd_col = slot_q[rd_slot];

endmodule

// File: rtl/ilv_col_walker.sv
// Steps through a matrix column by column, columns taken in table order.
// Position = row_base + table[slot]; row_base advances by the column count.
module ilv_col_walker #(
    parameter int LEN_W = 7,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,      // treat current position as the origin
    input  logic             step,     // advance after the current position
    input  logic             rewind,   // next position is the origin
    input  logic [LEN_W-1:0] cols,
    input  logic [LEN_W-1:0] len,
    input  logic [IDX_W-1:0] slot_col,
    output logic [IDX_W-1:0] slot,
    output logic [LEN_W-1:0] pos
);

    typedef struct packed {
        logic [LEN_W-1:0] row_base;
        logic [IDX_W-1:0] slot;
    } walk_t;

    walk_t walk_q, walk_d, cur;

    always_comb begin
        cur    = clr ? '0 : walk_q;
        slot   = cur.slot;
        pos    = cur.row_base + LEN_W'(slot_col);
        walk_d = walk_q;
        if (rewind) begin
            walk_d = '0;
        end else if (step) begin
            if ((cur.row_base + cols) >= len) begin
                walk_d.row_base = '0;
                walk_d.slot     = cur.slot + IDX_W'(1);
            end else begin
                walk_d.row_base = cur.row_base + cols;
                walk_d.slot     = cur.slot;
            end
        end else if (clr) begin
            walk_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

endmodule

// File: rtl/ilv_frame_buf.sv
module ilv_frame_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cell_q[wr_addr] <= wr_data;
    end

    assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/symbol_interleaver.sv
module symbol_interleaver
    import ilv_pkg::*;
#(
    parameter  int DATA_W   = 8,
    parameter  int MAX_COLS = 8,
    parameter  int MAX_LEN  = 64,
    localparam int LEN_W    = $clog2(MAX_LEN + 1),
    localparam int ADDR_W   = $clog2(MAX_LEN),
    localparam int COL_W    = $clog2(MAX_COLS + 1),
    localparam int IDX_W    = $clog2(MAX_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_slot,
    input  logic [IDX_W-1:0]  tbl_wr_col,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              frame_err
);

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cols;
        logic             mode;
        logic             err;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             acc, start, fill_wr, fill_last, out_fire, drain_last;
    logic             eff_mode;
    logic [LEN_W-1:0] eff_len, eff_cols, seq_cnt;
    logic [IDX_W-1:0] walk_slot, slot_col;
    logic [LEN_W-1:0] walk_pos;
    logic [ADDR_W-1:0] wr_addr, rd_addr;

    ilv_perm_table #(
        .MAX_COLS (MAX_COLS),
        .IDX_W    (IDX_W)
    ) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en && (ctl_q.phase == PH_IDLE)),
        .wr_slot (tbl_wr_slot),
        .wr_col  (tbl_wr_col),
        .rd_slot (walk_slot),
        .rd_col  (slot_col)
    );

    ilv_col_walker #(
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) i_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .step     (fill_wr || out_fire),
        .rewind   (fill_last || drain_last),
        .cols     (eff_cols),
        .len      (eff_len),
        .slot_col (slot_col),
        .slot     (walk_slot),
        .pos      (walk_pos)
    );

    ilv_frame_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_LEN),
        .ADDR_W (ADDR_W)
    ) i_buf (
        .clk     (clk),
        .wr_en   (fill_wr),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (out_data)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;

        // Handshake decode
        in_ready   = (ctl_q.phase != PH_DRAIN);
        acc        = in_valid && in_ready;
        start      = acc && in_sof;
        fill_wr    = acc && (in_sof || (ctl_q.phase == PH_FILL));
        out_valid  = (ctl_q.phase == PH_DRAIN);
        out_last   = out_valid && ((ctl_q.cnt + LEN_W'(1)) == ctl_q.len);
        out_fire   = out_valid && out_ready;
        drain_last = out_fire && out_last;

        // Configuration in force this cycle: fresh on a start symbol
        eff_mode  = start ? cfg_mode : ctl_q.mode;
        eff_len   = start ? cfg_len : ctl_q.len;
        eff_cols  = start ? LEN_W'(cfg_cols) : ctl_q.cols;
        seq_cnt   = start ? '0 : ctl_q.cnt;
        fill_last = fill_wr && ((seq_cnt + LEN_W'(1)) == eff_len);

        // Sequential side vs permuted side depends on direction
        wr_addr = eff_mode   ? ADDR_W'(walk_pos) : ADDR_W'(seq_cnt);
        rd_addr = ctl_q.mode ? ADDR_W'(ctl_q.cnt) : ADDR_W'(walk_pos);

        if (start) begin
            ctl_d.mode = cfg_mode;
            ctl_d.len  = cfg_len;
            ctl_d.cols = LEN_W'(cfg_cols);
            if (ctl_q.phase == PH_FILL) ctl_d.err = 1'b1;
        end

        if (acc && !in_sof && (ctl_q.phase == PH_IDLE)) begin
            ctl_d.err = 1'b1;
        end

        if (fill_wr) begin
            ctl_d.phase = PH_FILL;
            ctl_d.cnt   = seq_cnt + LEN_W'(1);
            if (fill_last) begin
                ctl_d.phase = PH_DRAIN;
                ctl_d.cnt   = '0;
            end
        end

        if (out_fire) begin
            ctl_d.cnt = ctl_q.cnt + LEN_W'(1);
            if (out_last) begin
                ctl_d.phase = PH_IDLE;
                ctl_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign frame_err = ctl_q.err;

endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              frame_err
);

    // R4
    out_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R5
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(in_valid && in_ready));

endmodule

bind symbol_interleaver ilv_checker #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .frame_err (frame_err)
);

// File: tb/test_symbol_interleaver.sv
`timescale 1ns/1ps
module test_symbol_interleaver;

    localparam int DATA_W = 8;
    localparam int MAX_COLS = 8;
    localparam int MAX_LEN = 64;
    localparam int LEN_W = 7;
    localparam int COL_W = 4;
    localparam int IDX_W = 3;

    typedef struct packed {
        logic        mode;
        logic [6:0]  len;
        logic [3:0]  cols;
        logic [31:0] perm;   // slot j in nibble j
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 7'd9,  4'd3, 32'h7654_3210},
        '{1'b0, 7'd12, 4'd4, 32'h0000_1302},
        '{1'b1, 7'd12, 4'd4, 32'h0000_1302},
        '{1'b0, 7'd16, 4'd8, 32'h0123_4567},
        '{1'b1, 7'd64, 4'd8, 32'h4625_0713},
        '{1'b0, 7'd5,  4'd1, 32'h0000_0000},
        '{1'b0, 7'd8,  4'd8, 32'h7654_3201},
        '{1'b1, 7'd1,  4'd1, 32'h0000_0000}
    };
    localparam logic [31:0] IDENT = 32'h7654_3210;

    logic              clk, rst_n;
    logic              cfg_mode;
    logic [LEN_W-1:0]  cfg_len;
    logic [COL_W-1:0]  cfg_cols;
    logic              tbl_wr_en;
    logic [IDX_W-1:0]  tbl_wr_slot, tbl_wr_col;
    logic              in_valid, in_ready, in_sof;
    logic [DATA_W-1:0] in_data;
    logic              out_valid, out_ready, out_last, frame_err;
    logic [DATA_W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int src [64];
    int exp_q [64];
    int got [64];

    symbol_interleaver #(
        .DATA_W (DATA_W), .MAX_COLS (MAX_COLS), .MAX_LEN (MAX_LEN)
    ) i_symbol_interleaver (
        .clk (clk), .rst_n (rst_n),
        .cfg_mode (cfg_mode), .cfg_len (cfg_len), .cfg_cols (cfg_cols),
        .tbl_wr_en (tbl_wr_en), .tbl_wr_slot (tbl_wr_slot), .tbl_wr_col (tbl_wr_col),
        .in_valid (in_valid), .in_ready (in_ready), .in_sof (in_sof), .in_data (in_data),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_last (out_last), .frame_err (frame_err)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model(input vec_t v);
        int rows = int'(v.len) / int'(v.cols);
        int k = 0;
        int tmp [64];
        for (int j = 0; j < int'(v.cols); j++) begin
            int p = int'(v.perm[4*j +: 4]);
            for (int r = 0; r < rows; r++) begin
                if (v.mode == 1'b0) exp_q[k] = src[r*int'(v.cols) + p];
                else                tmp[r*int'(v.cols) + p] = src[k];
                k++;
            end
        end
        if (v.mode == 1'b1)
            for (int i = 0; i < int'(v.len); i++) exp_q[i] = tmp[i];
    endfunction

    task automatic program_perm(input logic [31:0] perm);
        for (int j = 0; j < MAX_COLS; j++) begin
            @(negedge clk);
            tbl_wr_en = 1'b1;
            tbl_wr_slot = IDX_W'(j);
            tbl_wr_col = perm[4*j +: 3];
            @(posedge clk);
        end
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Sends one frame; config is scrambled after the start symbol (R11).
    task automatic send_frame(input vec_t v, input int err_k, input bit poke);
        for (int k = 0; k < int'(v.len); k++) begin
            @(negedge clk);
            if (k == 0) begin
                cfg_mode = v.mode; cfg_len = v.len; cfg_cols = v.cols;
            end else begin
                cfg_mode = ~v.mode; cfg_len = 7'd2; cfg_cols = 4'd2;
                check(frame_err == (k == err_k), "R7", "frame_err", int'(frame_err), int'(k == err_k));
            end
            tbl_wr_en = poke && (k == 2);
            tbl_wr_slot = 3'd0; tbl_wr_col = 3'd3;
            in_valid = 1'b1; in_sof = (k == 0); in_data = DATA_W'(src[k]);
            check(!out_valid && in_ready, "R4", "out_valid during fill", int'(out_valid), 0);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; tbl_wr_en = 1'b0;
    endtask

    task automatic recv_frame(input int len, input bit stall_en, input string req, input bit poke);
        int n = 0;
        int guard = 0;
        bit was_stall = 1'b0;
        logic [DATA_W-1:0] held = '0;
        while (n < len && guard < 5000) begin
            bit stall;
            @(negedge clk);
            guard++;
            tbl_wr_en = poke && (guard == 1);
            tbl_wr_slot = 3'd1; tbl_wr_col = 3'd0;
            stall = stall_en && (guard % 3 == 0);
            out_ready = !stall;
            if (was_stall)
                check(out_valid && (out_data == held), "R9", "held data", int'(out_data), int'(held));
            was_stall = 1'b0;
            if (out_valid) begin
                check(!in_ready, "R4", "in_ready during drain", int'(in_ready), 0);
                if (stall) begin
                    held = out_data;
                    was_stall = 1'b1;
                end else begin
                    check(int'(out_data) == (exp_q[n] & 255), req, "out_data", int'(out_data), exp_q[n] & 255);
                    check(out_last == (n == len - 1), "R5", "out_last", int'(out_last), int'(n == len - 1));
                    got[n] = int'(out_data);
                    n++;
                end
            end
            @(posedge clk);
        end
        @(negedge clk);
        out_ready = 1'b0; tbl_wr_en = 1'b0;
        check(n == len, req, "symbol count", n, len);
        check(!out_valid && in_ready, "R5", "idle after last", int'(out_valid), 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        vec_t v;
        rst_n = 1'b0; cfg_mode = 1'b0; cfg_len = '0; cfg_cols = '0;
        tbl_wr_en = 1'b0; tbl_wr_slot = '0; tbl_wr_col = '0;
        in_valid = 1'b0; in_sof = 1'b0; in_data = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(in_ready, "R10", "in_ready", int'(in_ready), 1);
        check(!out_valid, "R10", "out_valid", int'(out_valid), 0);
        check(!frame_err, "R10", "frame_err", int'(frame_err), 0);

        // R10 + R3: identity table straight after reset, 9 symbols, 3 columns
        v = VECS[0];
        for (int k = 0; k < 9; k++) src[k] = k + 1;
        exp_q[0] = 1; exp_q[1] = 4; exp_q[2] = 7; exp_q[3] = 2; exp_q[4] = 5;
        exp_q[5] = 8; exp_q[6] = 3; exp_q[7] = 6; exp_q[8] = 9;
        send_frame(v, -1, 1'b0);
        recv_frame(9, 1'b0, "R3 R10", 1'b0);
        // R3 round trip back through deinterleave
        for (int k = 0; k < 9; k++) src[k] = got[k];
        for (int k = 0; k < 9; k++) exp_q[k] = k + 1;
        v.mode = 1'b1;
        send_frame(v, -1, 1'b0);
        recv_frame(9, 1'b1, "R3", 1'b0);

        // Vector table: R1 / R2 with R11 config scrambling, R9 stalls on odd entries
        for (int c = 0; c < 8; c++) begin
            v = VECS[c];
            program_perm(v.perm);
            for (int k = 0; k < int'(v.len); k++) src[k] = (c*37 + k*5 + 1) & 255;
            model(v);
            send_frame(v, -1, 1'b0);
            recv_frame(int'(v.len), c[0], v.mode ? "R2 R11" : "R1 R11", 1'b0);
        end

        // R6: table writes during fill and drain are ignored
        v = VECS[1];
        program_perm(v.perm);
        for (int k = 0; k < 12; k++) src[k] = 100 + k;
        model(v);
        send_frame(v, -1, 1'b1);
        recv_frame(12, 1'b0, "R6", 1'b1);
        send_frame(v, -1, 1'b0);
        recv_frame(12, 1'b0, "R6", 1'b0);

        // R7: frame cut short by a new start symbol
        program_perm(IDENT);
        v = '{1'b0, 7'd6, 4'd2, IDENT};
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cfg_mode = v.mode; cfg_len = v.len; cfg_cols = v.cols;
            in_valid = 1'b1; in_sof = (k == 0); in_data = DATA_W'(8'hE0 + k);
            @(posedge clk);
        end
        for (int k = 0; k < 6; k++) src[k] = 50 + 3*k;
        model(v);
        send_frame(v, 1, 1'b0);
        recv_frame(6, 1'b0, "R7", 1'b0);

        // R8: stray symbol while idle
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_data = 8'hAA;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(frame_err, "R8", "frame_err pulse", int'(frame_err), 1);
        check(!out_valid && in_ready, "R8", "still idle", int'(out_valid), 0);
        @(negedge clk);
        check(!frame_err, "R8", "pulse width", int'(frame_err), 0);
        for (int k = 0; k < 6; k++) src[k] = 200 + k;
        model(v);
        send_frame(v, -1, 1'b0);
        recv_frame(6, 1'b1, "R8", 1'b0);

        summary();
        $finish;
    end

endmodule